// File: doc/BRIEF.md
# Free-Running SDRAM Command Pattern Generator

This block produces the stream of words that a memory-write controller stores into an SDRAM so that, once the data outputs are looped back onto the command and address pins, the memory replays its own command sequence forever. Every location of every page gets a word. A word holds a 4-bit command, a bank-address field and a row/column address field. The block visits all locations, with the column changing fastest, then the bank, then the row. It offers each word on a valid/ready stream together with the location where the word is to be written.

Each page (one bank, one row) holds three live commands. The first closes the bank that was burst before. The second opens the bank that is burst next. The third starts a read burst on that newly opened bank. All other locations hold an inhibit command, but they still carry address data. The read burst wraps around the page and always starts at column equal to the row number. For that reason, the three command slots are rotated by the row number. The result is that the low address bits hold the row value for a whole page, and a slow observer can sample them to learn which row the loop is on.

The following are parameters: the bank count (2 or 4), the row count, the page length (a power of two), the base slot of each command and the address bit that carries the bank select in the 2-bank variant.

Top module: `fr_cmd_gen`

## Requirements
- R1: After reset the first offered location is row 0, bank 0, column 0. Each accepted word (wrValid and wrReady high at a clock edge) moves to the next location: column first, then bank, then row. No location is skipped or repeated.
- R2: wrValid is high and done is low from the first cycle after reset. After the word at the last column of the last bank of the last row is accepted, done goes high, wrValid goes low, and both stay that way. The location outputs then hold the last location.
- R3: At column (PRE_OFS + row) mod PAGE_LEN the command is precharge, encoded {CS#,RAS#,CAS#,WE#} = 4'b0010. Its bank is (bank − 1) mod NUM_BANKS. Address bit 10 is 0 and the low address bits carry the current row.
- R4: At column (ACT_OFS + row) mod PAGE_LEN the command is activate, 4'b0011. Its bank is (bank + 1) mod NUM_BANKS. The address carries the current row, except in the last bank, where it carries (row + 1) mod NUM_ROWS.
- R5: At column (RD_OFS + row) mod PAGE_LEN the command is read, 4'b0101. Its bank and address are the same as the activate command of the same page, so the start column equals the row that is opened.
- R6: Every other location holds inhibit, 4'b1111. Its bank field is the current bank and its address carries the current row.
- R7: With 4 banks, the bank field appears on the 2-bit bank-address output and the address bits above the row field are 0. With 2 banks, the bank-address output is 0 and the bank field appears on address bit BANK_PIN (default 11).
- R8: While wrValid is high and wrReady is low, every stream output holds its value at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrValid | output | 1 | A word is offered |
| wrReady | input | 1 | The write controller accepts the offered word |
| wrBank | output | BANK_W | Bank of the location to write |
| wrRow | output | ROW_W | Row of the location to write |
| wrCol | output | COL_W | Column of the location to write |
| wrCmd | output | 4 | Stored command {CS#,RAS#,CAS#,WE#} |
| wrBa | output | BA_W | Stored bank-address bits |
| wrAddr | output | ADDR_W | Stored address bits |
| done | output | 1 | Every location has been emitted |

## Verification
The bench sweeps a 4-bank and a 2-bank instance through every location while wrReady stutters. This exposes a design that steps on a stalled cycle or holds on an accepted one, because the location sequence would then drift from the model. Each page is compared with an independent model of the rotated slots. An unrotated slot, a wrong previous or next bank at bank 0 or the last bank, or an activate that fails to advance the row at the last bank would each show up as a word mismatch. The wrap of the last row back to row 0 and the move of the bank bit onto the address pin in the 2-bank case are checked the same way. The end of the sweep is checked to confirm that done rises exactly once, valid drops, and further ready cycles change nothing.

// File: rtl/fr_cmd_pkg.sv
package fr_cmd_pkg;
  typedef logic [3:0] sdCmd_t;

  // {CS#, RAS#, CAS#, WE#}
  localparam sdCmd_t CMD_PRE = 4'b0010;
  localparam sdCmd_t CMD_ACT = 4'b0011;
  localparam sdCmd_t CMD_RD  = 4'b0101;
  localparam sdCmd_t CMD_NOP = 4'b1111;

  typedef struct packed {
    logic stepCol;
    logic stepBank;
    logic stepRow;
  } frStrobe_t;
endpackage

// File: rtl/fr_cmd_ctrl.sv
module fr_cmd_ctrl
  import fr_cmd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrReady,
  input  logic      lastCol,
  input  logic      lastBank,
  input  logic      lastRow,
  output frStrobe_t strb,
  output logic      wrValid,
  output logic      done
);
  logic fire;
  logic finalWord;

  assign wrValid   = !done;
  assign fire      = wrValid && wrReady;
  assign finalWord = lastCol && lastBank && lastRow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done <= 1'b0;
    end else if (fire && finalWord) begin
      done <= 1'b1;
    end
  end

  always_comb begin
    strb.stepCol  = fire && !finalWord;
    strb.stepBank = fire && !finalWord && lastCol;
    strb.stepRow  = fire && !finalWord && lastCol && lastBank;
  end
endmodule

// File: rtl/fr_cmd_dp.sv
module fr_cmd_dp
  import fr_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int NUM_ROWS  = 8,
  parameter int PAGE_LEN  = 16,
  parameter int ADDR_W    = 12,
  parameter int BA_W      = 2,
  parameter int BANK_PIN  = 11,
  parameter int PRE_OFS   = 1,
  parameter int ACT_OFS   = 5,
  parameter int RD_OFS    = 9,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ROW_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int COL_W    = (PAGE_LEN > 1) ? $clog2(PAGE_LEN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  frStrobe_t         strb,
  output logic              lastCol,
  output logic              lastBank,
  output logic              lastRow,
  output logic [BANK_W-1:0] wrBank,
  output logic [ROW_W-1:0]  wrRow,
  output logic [COL_W-1:0]  wrCol,
  output sdCmd_t            wrCmd,
  output logic [BA_W-1:0]   wrBa,
  output logic [ADDR_W-1:0] wrAddr
);
  localparam int AP_BIT = 10;

  logic [BANK_W-1:0] bankQ, bankPrev, bankNext, bankSel;
  logic [ROW_W-1:0]  rowQ, rowNext, actRow, rowSel;
  logic [COL_W-1:0]  colQ, rowRot, preSlot, actSlot, rdSlot;
  logic              isPre, isAct, isRd;
  logic [ADDR_W-1:0] baseAddr;

  assign lastCol  = (colQ  == COL_W'(PAGE_LEN - 1));
  assign lastBank = (bankQ == BANK_W'(NUM_BANKS - 1));
  assign lastRow  = (rowQ  == ROW_W'(NUM_ROWS - 1));

  // location counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colQ  <= '0;
      bankQ <= '0;
      rowQ  <= '0;
    end else begin
      if (strb.stepCol)  colQ  <= lastCol  ? '0 : colQ + 1'b1;
      if (strb.stepBank) bankQ <= lastBank ? '0 : bankQ + 1'b1;
      if (strb.stepRow)  rowQ  <= rowNext;
    end
  end

  // neighbour banks and rows
  assign bankPrev = (bankQ == '0) ? BANK_W'(NUM_BANKS - 1) : bankQ - 1'b1;
  assign bankNext = lastBank ? '0 : bankQ + 1'b1;
  assign rowNext  = lastRow  ? '0 : rowQ + 1'b1;
  assign actRow   = lastBank ? rowNext : rowQ;

  // slot positions rotated by the current row
  assign rowRot  = COL_W'(rowQ);
  assign preSlot = COL_W'(PRE_OFS) + rowRot;
  assign actSlot = COL_W'(ACT_OFS) + rowRot;
  assign rdSlot  = COL_W'(RD_OFS)  + rowRot;

  assign isPre = (colQ == preSlot);
  assign isAct = !isPre && (colQ == actSlot);
  assign isRd  = !isPre && !isAct && (colQ == rdSlot);

  always_comb begin
    wrCmd   = CMD_NOP;
    bankSel = bankQ;
    rowSel  = rowQ;
    if (isPre) begin
      wrCmd   = CMD_PRE;
      bankSel = bankPrev;
    end else if (isAct || isRd) begin
      wrCmd   = isAct ? CMD_ACT : CMD_RD;
      bankSel = bankNext;
      rowSel  = actRow;
    end
  end

  always_comb begin
    baseAddr = '0;
    baseAddr[ROW_W-1:0] = rowSel;
    if (isPre) baseAddr[AP_BIT] = 1'b0;
  end

  // bank select placement depends on the bank count
  generate
    if (NUM_BANKS == 2) begin : g_twoBank
      always_comb begin
        wrAddr           = baseAddr;
        wrAddr[BANK_PIN] = bankSel[0];
        wrBa             = '0;
      end
    end else begin : g_multiBank
      always_comb begin
        wrAddr = baseAddr;
        wrBa   = BA_W'(bankSel);
      end
    end
  endgenerate

  assign wrBank = bankQ;
  assign wrRow  = rowQ;
  assign wrCol  = colQ;
endmodule

// File: rtl/fr_cmd_gen.sv
module fr_cmd_gen
  import fr_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int NUM_ROWS  = 8,
  parameter int PAGE_LEN  = 16,
  parameter int ADDR_W    = 12,
  parameter int BA_W      = 2,
  parameter int BANK_PIN  = 11,
  parameter int PRE_OFS   = 1,
  parameter int ACT_OFS   = 5,
  parameter int RD_OFS    = 9,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ROW_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int COL_W    = (PAGE_LEN > 1) ? $clog2(PAGE_LEN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [BANK_W-1:0] wrBank,
  output logic [ROW_W-1:0]  wrRow,
  output logic [COL_W-1:0]  wrCol,
  output logic [3:0]        wrCmd,
  output logic [BA_W-1:0]   wrBa,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              done
);
  frStrobe_t strb;
  logic      lastCol, lastBank, lastRow;

  fr_cmd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrReady  (wrReady),
    .lastCol  (lastCol),
    .lastBank (lastBank),
    .lastRow  (lastRow),
    .strb     (strb),
    .wrValid  (wrValid),
    .done     (done)
  );

  fr_cmd_dp #(
    .NUM_BANKS (NUM_BANKS),
    .NUM_ROWS  (NUM_ROWS),
    .PAGE_LEN  (PAGE_LEN),
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .BANK_PIN  (BANK_PIN),
    .PRE_OFS   (PRE_OFS),
    .ACT_OFS   (ACT_OFS),
    .RD_OFS    (RD_OFS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .lastCol  (lastCol),
    .lastBank (lastBank),
    .lastRow  (lastRow),
    .wrBank   (wrBank),
    .wrRow    (wrRow),
    .wrCol    (wrCol),
    .wrCmd    (wrCmd),
    .wrBa     (wrBa),
    .wrAddr   (wrAddr)
  );
endmodule

// File: rtl/fr_cmd_gen_chk.sv
module fr_cmd_gen_chk #(
  parameter int NUM_BANKS = 4,
  parameter int PAGE_LEN  = 16,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 3,
  parameter int COL_W     = 4,
  parameter int ADDR_W    = 12,
  parameter int BA_W      = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic              wrReady,
  input logic [BANK_W-1:0] wrBank,
  input logic [ROW_W-1:0]  wrRow,
  input logic [COL_W-1:0]  wrCol,
  input logic [3:0]        wrCmd,
  input logic [BA_W-1:0]   wrBa,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              done
);
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrBank) && $stable(wrRow) &&
                               $stable(wrCol) && $stable(wrCmd) && $stable(wrBa) &&
                               $stable(wrAddr)));

  assert_col_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady && wrCol != COL_W'(PAGE_LEN - 1)) |=>
      (wrCol == $past(wrCol) + 1'b1 && wrBank == $past(wrBank) && wrRow == $past(wrRow)));

  assert_done_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (done && !wrValid));

  assert_done_no_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !wrValid);

  assert_pre_a10_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrCmd == 4'b0010) |-> !wrAddr[10]);

  assert_cmd_legal_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrCmd == 4'b0010 || wrCmd == 4'b0011 ||
                 wrCmd == 4'b0101 || wrCmd == 4'b1111));

  assert_two_bank_ba_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && NUM_BANKS == 2) |-> (wrBa == '0));
endmodule

bind fr_cmd_gen fr_cmd_gen_chk #(
  .NUM_BANKS (NUM_BANKS),
  .PAGE_LEN  (PAGE_LEN),
  .BANK_W    (BANK_W),
  .ROW_W     (ROW_W),
  .COL_W     (COL_W),
  .ADDR_W    (ADDR_W),
  .BA_W      (BA_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrValid (wrValid),
  .wrReady (wrReady),
  .wrBank  (wrBank),
  .wrRow   (wrRow),
  .wrCol   (wrCol),
  .wrCmd   (wrCmd),
  .wrBa    (wrBa),
  .wrAddr  (wrAddr),
  .done    (done)
);

// File: tb/fr_cmd_gen_bench.sv
`timescale 1ns/1ps
module fr_cmd_gen_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  // instance A: 4 banks, 8 rows, page 16, slots 1/5/9
  logic       vA, rA, dA;
  logic [1:0] bankA;
  logic [2:0] rowA;
  logic [3:0] colA, cmdA;
  logic [1:0] baA;
  logic [11:0] addrA;

  fr_cmd_gen u_fr_cmd_gen (
    .clk(clk), .rstN(rstN), .wrValid(vA), .wrReady(rA),
    .wrBank(bankA), .wrRow(rowA), .wrCol(colA), .wrCmd(cmdA),
    .wrBa(baA), .wrAddr(addrA), .done(dA)
  );

  // instance B: 2 banks, 4 rows, page 8, slots 0/3/6
  logic       vB, rB, dB;
  logic [0:0] bankB;
  logic [1:0] rowB;
  logic [2:0] colB;
  logic [3:0] cmdB;
  logic [1:0] baB;
  logic [11:0] addrB;

  fr_cmd_gen #(
    .NUM_BANKS(2), .NUM_ROWS(4), .PAGE_LEN(8),
    .PRE_OFS(0), .ACT_OFS(3), .RD_OFS(6)
  ) u_fr_cmd_gen_two (
    .clk(clk), .rstN(rstN), .wrValid(vB), .wrReady(rB),
    .wrBank(bankB), .wrRow(rowB), .wrCol(colB), .wrCmd(cmdB),
    .wrBa(baB), .wrAddr(addrB), .done(dB)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // observation of the selected instance
  task automatic observe(input int which, output int v, output int d, output int loc,
                         output int word);
    if (which == 0) begin
      v = int'(vA); d = int'(dA);
      loc  = (int'(rowA) << 16) | (int'(bankA) << 8) | int'(colA);
      word = (int'(cmdA) << 16) | (int'(baA) << 12) | int'(addrA);
    end else begin
      v = int'(vB); d = int'(dB);
      loc  = (int'(rowB) << 16) | (int'(bankB) << 8) | int'(colB);
      word = (int'(cmdB) << 16) | (int'(baB) << 12) | int'(addrB);
    end
  endtask

  // expected word from the requirements
  function automatic int expWord(input int nb, input int nr, input int pl,
                                 input int pre, input int act, input int rd,
                                 input int r, input int b, input int c,
                                 output string req);
    int cmd, tb, av, addr, ba;
    if (c == (pre + r) % pl) begin
      cmd = 4'b0010; tb = (b + nb - 1) % nb; av = r; req = "R3";
    end else if (c == (act + r) % pl) begin
      cmd = 4'b0011; tb = (b + 1) % nb; av = (b == nb - 1) ? (r + 1) % nr : r; req = "R4";
    end else if (c == (rd + r) % pl) begin
      cmd = 4'b0101; tb = (b + 1) % nb; av = (b == nb - 1) ? (r + 1) % nr : r; req = "R5";
    end else begin
      cmd = 4'b1111; tb = b; av = r; req = "R6";
    end
    addr = av;
    if (nb == 2) begin
      addr = addr | (tb << 11); ba = 0; req = {req, "/R7"};
    end else begin
      ba = tb;
    end
    return (cmd << 16) | (ba << 12) | addr;
  endfunction

  task automatic setReady(input int which, input logic val);
    if (which == 0) rA = val; else rB = val;
  endtask

  task automatic testReset();
    int v, d, loc, word;
    @(negedge clk);
    observe(0, v, d, loc, word);
    chk(v == 1, "R2", "valid after reset", v, 1);
    chk(d == 0, "R2", "done after reset", d, 0);
    chk(loc == 0, "R1", "first location", loc, 0);
    observe(1, v, d, loc, word);
    chk(v == 1 && d == 0, "R2", "two-bank valid/done after reset", (v << 1) | d, 2);
    chk(loc == 0, "R1", "two-bank first location", loc, 0);
  endtask

  task automatic testSweep(input int which, input int nb, input int nr, input int pl,
                           input int pre, input int act, input int rd,
                           input logic [15:0] seed);
    int r = 0, b = 0, c = 0, count = 0;
    int total = nb * nr * pl;
    int v, d, loc, word, ew, holdLoc = 0, holdWord = 0;
    bit stalled = 1'b0;
    string req;
    logic [15:0] lfsr = seed;
    while (count < total) begin
      @(negedge clk);
      observe(which, v, d, loc, word);
      chk(v == 1 && d == 0, "R2", "valid during sweep", (v << 1) | d, 2);
      chk(loc == ((r << 16) | (b << 8) | c), "R1", "location order", loc,
          (r << 16) | (b << 8) | c);
      ew = expWord(nb, nr, pl, pre, act, rd, r, b, c, req);
      chk(word == ew, req, "stored word", word, ew);
      if (stalled) begin
        chk(loc == holdLoc && word == holdWord, "R8", "hold under stall", word, holdWord);
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[1:0] != 2'b00) begin
        setReady(which, 1'b1);
        stalled = 1'b0;
        count++;
        c++;
        if (c == pl) begin
          c = 0; b++;
          if (b == nb) begin b = 0; r++; end
        end
      end else begin
        setReady(which, 1'b0);
        stalled = 1'b1;
        holdLoc = loc; holdWord = word;
      end
    end
    // keep ready high after the last word; nothing may move
    setReady(which, 1'b1);
    repeat (3) begin
      @(negedge clk);
      observe(which, v, d, loc, word);
      chk(d == 1, "R2", "done after last word", d, 1);
      chk(v == 0, "R2", "valid low after done", v, 0);
      chk(loc == (((nr - 1) << 16) | ((nb - 1) << 8) | (pl - 1)), "R2", "location held",
          loc, ((nr - 1) << 16) | ((nb - 1) << 8) | (pl - 1));
    end
    setReady(which, 1'b0);
  endtask

  initial begin
    rA = 1'b0;
    rB = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSweep(0, 4, 8, 16, 1, 5, 9, 16'hACE1);
    testSweep(1, 2, 4, 8, 0, 3, 6, 16'h1D2F);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule